// File: doc/BRIEF.md
# UART Transmit/Receive FIFO Pair with Trigger Levels

This block sits between a serial line engine and the register side of a UART. It keeps two byte queues: a transmit queue that software fills and the serial engine drains, and a receive queue that the serial engine fills and software drains. Each queue holds up to 64 bytes when queueing is switched on. When queueing is switched off, each side acts as a one-byte holding register.

A single control byte sets the mode. It selects a receive threshold and a transmit threshold, and it can clear either queue. From these settings the block drives two level outputs, `rx_trig` and `tx_trig`, for the interrupt logic. It also reports both fill levels and a five-bit status word.

The three flow-controlled ports follow valid/ready rules. A byte moves on a rising clock edge when valid and ready are both high. A producer holds its data stable while valid is high and ready is low.

- Host transmit push: ready is low while the transmit queue is full. A valid byte offered against a low ready is simply not taken.
- Engine transmit pop and host receive pop: valid is high whenever the queue holds data, and the data shown is the oldest byte.
- Engine receive push: this port has no ready, because the line cannot be stalled. A byte that arrives while the receive queue is full is discarded and raises a sticky overrun flag.

Top module: `uart_fifo_pair`

## Requirements
- R1: After reset both queues are empty and both levels read 0. The control byte is 0, so queueing is off. `status` reads 5'b00110, `tx_trig` is 1, and `rx_trig` and `rx_overrun` are 0.
- R2: Each queue delivers bytes in the order they were accepted. With queueing on (control bit 0 set), each queue holds 64 bytes.
- R3: `host_tx_ready` is low exactly when the transmit queue is full. A push offered while it is low leaves the queue and its level unchanged.
- R4: A receive push while the receive queue is full drops the byte and sets `rx_overrun`. The flag stays set until the receive queue is cleared, by control bit 1 or by a change of control bit 0.
- R5: A control write with bit 1 set empties the receive queue and clears `rx_overrun`. A control write with bit 2 set empties the transmit queue. Both take effect at the write edge. Neither bit is stored, so pushes on the next cycle are accepted normally. A clear overrides any push or pop in the same cycle.
- R6: `rx_trig` is high while the receive level is at or above the threshold chosen by control bits 7:6. The codes are 0 = 1 byte, 1 = 16 bytes, 2 = 32 bytes, 3 = 62 bytes. With queueing off, the threshold is 1.
- R7: `tx_trig` is high while the transmit level is at or below the threshold chosen by control bits 5:4. The codes are 0 = 0 bytes, 1 = 2 bytes, 2 = 16 bytes, 3 = 32 bytes. With queueing off, the threshold is 0.
- R8: The `status` bits are as follows:
  - bit 0: either queue holds data.
  - bit 1: the transmit queue is not full.
  - bit 2: the transmit queue is empty.
  - bit 3: the receive queue is not empty.
  - bit 4: the receive queue is full.
- R9: `tx_level` and `rx_level` give each queue's current byte count, zero-extended to 9 bits.
- R10: With control bit 0 clear, each queue holds at most one byte.
- R11: A control write that changes bit 0 empties both queues.
- R12: A pop offered against an empty queue has no effect. Valid stays low and the level stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_byte | input | 8 | Control byte: bit0 queue enable, bit1 receive clear, bit2 transmit clear, 5:4 transmit threshold, 7:6 receive threshold |
| host_tx_valid | input | 1 | Host offers a transmit byte |
| host_tx_data | input | 8 | Transmit byte from host |
| host_tx_ready | output | 1 | Transmit queue can accept a byte |
| eng_tx_valid | output | 1 | Transmit queue holds a byte for the engine |
| eng_tx_data | output | 8 | Oldest transmit byte |
| eng_tx_ready | input | 1 | Engine takes the transmit byte |
| eng_rx_valid | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte from engine |
| host_rx_valid | output | 1 | Receive queue holds a byte for the host |
| host_rx_data | output | 8 | Oldest received byte |
| host_rx_ready | input | 1 | Host takes the received byte |
| rx_overrun | output | 1 | Sticky receive overrun flag |
| rx_trig | output | 1 | Receive threshold reached |
| tx_trig | output | 1 | Transmit level at or under threshold |
| status | output | 5 | Status word (see R8) |
| tx_level | output | 9 | Transmit queue byte count |
| rx_level | output | 9 | Receive queue byte count |

## Verification
Every push, pop and control write is registered once. The levels, the status word, the valid/ready outputs, the overrun flag and both triggers therefore all show their new values in the cycle after the edge that took the stimulus. The triggers, status and ready have no further register stage, because they are decoded combinationally from the counts and the stored control byte. The bench drives each stimulus on a falling edge and lets one rising edge pass. It then compares every output with a queue model on the next falling edge. Each check therefore lands exactly one edge after the stimulus that caused it.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  // control byte bit positions (software-visible encoding)
  localparam int CTL_EN    = 0;
  localparam int CTL_RXCLR = 1;
  localparam int CTL_TXCLR = 2;
  localparam int CTL_TXT_LO = 4;
  localparam int CTL_RXT_LO = 6;

  // status word bit positions
  localparam int ST_BUSY   = 0;
  localparam int ST_TXNF   = 1;
  localparam int ST_TXEMP  = 2;
  localparam int ST_RXNE   = 3;
  localparam int ST_RXFULL = 4;
  localparam int ST_W      = 5;

  typedef struct packed {
    logic [1:0] rx_code;
    logic [1:0] tx_code;
    logic       en;
  } fifo_cfg_t;
endpackage

// File: rtl/uf_byte_fifo.sv
module uf_byte_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           flush,
  input  logic                           one_slot,
  input  logic                           push,
  input  logic [WIDTH-1:0]               push_data,
  input  logic                           pop,
  output logic [WIDTH-1:0]               pop_data,
  output logic [$clog2(DEPTH+1)-1:0]     count,
  output logic                           full,
  output logic                           empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] CAP_DEEP = CW'(DEPTH);
  localparam logic [CW-1:0] CAP_ONE  = CW'(1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             push_ok, pop_ok;
  logic [CW-1:0]    cap;

  assign cap     = one_slot ? CAP_ONE : CAP_DEEP;
  assign full    = (count == cap);
  assign empty   = (count == '0);
  assign push_ok = push & ~full & ~flush;
  assign pop_ok  = pop & ~empty & ~flush;
  assign pop_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CAP_DEEP);

  p_flush_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> (count == $past(count)));

  p_empty_pop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> (count == '0));
endmodule

// File: rtl/uf_trig.sv
module uf_trig #(
  parameter int DEPTH = 64,
  parameter bit IS_RX = 1'b1
) (
  input  logic [$clog2(DEPTH+1)-1:0] count,
  input  logic [1:0]                 code,
  input  logic                       en,
  output logic                       trig
);
  localparam int CW = $clog2(DEPTH+1);

  generate
    if (IS_RX) begin : g_rx
      localparam logic [CW-1:0] T0 = CW'(1);
      localparam logic [CW-1:0] T1 = CW'(DEPTH/4);
      localparam logic [CW-1:0] T2 = CW'(DEPTH/2);
      localparam logic [CW-1:0] T3 = CW'(DEPTH-2);
      logic [CW-1:0] thr;
      always_comb begin
        case (code)
          2'd0:    thr = T0;
          2'd1:    thr = T1;
          2'd2:    thr = T2;
          default: thr = T3;
        endcase
        if (!en) thr = T0;
      end
      assign trig = (count >= thr);
    end else begin : g_tx
      localparam logic [CW-1:0] T0 = CW'(0);
      localparam logic [CW-1:0] T1 = CW'(2);
      localparam logic [CW-1:0] T2 = CW'(DEPTH/4);
      localparam logic [CW-1:0] T3 = CW'(DEPTH/2);
      logic [CW-1:0] thr;
      always_comb begin
        case (code)
          2'd0:    thr = T0;
          2'd1:    thr = T1;
          2'd2:    thr = T2;
          default: thr = T3;
        endcase
        if (!en) thr = T0;
      end
      assign trig = (count <= thr);
    end
  endgenerate
endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  parameter int LVL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [7:0]       ctl_byte,
  input  logic             host_tx_valid,
  input  logic [WIDTH-1:0] host_tx_data,
  output logic             host_tx_ready,
  output logic             eng_tx_valid,
  output logic [WIDTH-1:0] eng_tx_data,
  input  logic             eng_tx_ready,
  input  logic             eng_rx_valid,
  input  logic [WIDTH-1:0] eng_rx_data,
  output logic             host_rx_valid,
  output logic [WIDTH-1:0] host_rx_data,
  input  logic             host_rx_ready,
  output logic             rx_overrun,
  output logic             rx_trig,
  output logic             tx_trig,
  output logic [ST_W-1:0]  status,
  output logic [LVL_W-1:0] tx_level,
  output logic [LVL_W-1:0] rx_level
);
  localparam int CW = $clog2(DEPTH+1);

  fifo_cfg_t     cfg;
  logic          en_flip, rx_flush, tx_flush;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          tx_full, tx_empty, rx_full, rx_empty;

  // a change of the enable bit, or an explicit clear bit, flushes a side
  assign en_flip  = ctl_wr & (ctl_byte[CTL_EN] != cfg.en);
  assign rx_flush = (ctl_wr & ctl_byte[CTL_RXCLR]) | en_flip;
  assign tx_flush = (ctl_wr & ctl_byte[CTL_TXCLR]) | en_flip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (ctl_wr) begin
      cfg.en      <= ctl_byte[CTL_EN];
      cfg.tx_code <= ctl_byte[CTL_TXT_LO +: 2];
      cfg.rx_code <= ctl_byte[CTL_RXT_LO +: 2];
    end
  end

  uf_byte_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush), .one_slot(~cfg.en),
    .push(host_tx_valid), .push_data(host_tx_data),
    .pop(eng_tx_ready), .pop_data(eng_tx_data),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  uf_byte_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush), .one_slot(~cfg.en),
    .push(eng_rx_valid), .push_data(eng_rx_data),
    .pop(host_rx_ready), .pop_data(host_rx_data),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  uf_trig #(.DEPTH(DEPTH), .IS_RX(1'b1)) u_rxtrig (
    .count(rx_cnt), .code(cfg.rx_code), .en(cfg.en), .trig(rx_trig)
  );

  uf_trig #(.DEPTH(DEPTH), .IS_RX(1'b0)) u_txtrig (
    .count(tx_cnt), .code(cfg.tx_code), .en(cfg.en), .trig(tx_trig)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          rx_overrun <= 1'b0;
    else if (rx_flush)                   rx_overrun <= 1'b0;
    else if (eng_rx_valid && rx_full)    rx_overrun <= 1'b1;
  end

  assign host_tx_ready = ~tx_full;
  assign eng_tx_valid  = ~tx_empty;
  assign host_rx_valid = ~rx_empty;
  assign tx_level      = {{(LVL_W-CW){1'b0}}, tx_cnt};
  assign rx_level      = {{(LVL_W-CW){1'b0}}, rx_cnt};

  always_comb begin
    status            = '0;
    status[ST_BUSY]   = ~tx_empty | ~rx_empty;
    status[ST_TXNF]   = ~tx_full;
    status[ST_TXEMP]  = tx_empty;
    status[ST_RXNE]   = ~rx_empty;
    status[ST_RXFULL] = rx_full;
  end

  p_ovr_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_overrun && !(ctl_wr && (ctl_byte[CTL_RXCLR] || ctl_byte[CTL_EN] != cfg.en)))
      |=> rx_overrun);

  p_holding_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.en |-> (tx_level <= LVL_W'(1) && rx_level <= LVL_W'(1)));

  p_txtrig_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == '0) |-> tx_trig);

  p_rxtrig_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == '0) |-> !rx_trig);

  p_enflip_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
    en_flip |=> (tx_level == '0 && rx_level == '0));
endmodule

// File: tb/uart_fifo_pair_bench.sv
`timescale 1ns/1ps
module uart_fifo_pair_bench;
  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctl_wr;
  logic [7:0] ctl_byte;
  logic       host_tx_valid, eng_tx_ready, eng_rx_valid, host_rx_ready;
  logic [7:0] host_tx_data, eng_rx_data;
  logic       host_tx_ready, eng_tx_valid, host_rx_valid;
  logic [7:0] eng_tx_data, host_rx_data;
  logic       rx_overrun, rx_trig, tx_trig;
  logic [4:0] status;
  logic [8:0] tx_level, rx_level;

  always #10 clk = ~clk;

  uart_fifo_pair u_uart_fifo_pair (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_byte(ctl_byte),
    .host_tx_valid(host_tx_valid), .host_tx_data(host_tx_data), .host_tx_ready(host_tx_ready),
    .eng_tx_valid(eng_tx_valid), .eng_tx_data(eng_tx_data), .eng_tx_ready(eng_tx_ready),
    .eng_rx_valid(eng_rx_valid), .eng_rx_data(eng_rx_data),
    .host_rx_valid(host_rx_valid), .host_rx_data(host_rx_data), .host_rx_ready(host_rx_ready),
    .rx_overrun(rx_overrun), .rx_trig(rx_trig), .tx_trig(tx_trig),
    .status(status), .tx_level(tx_level), .rx_level(rx_level)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [7:0] mtx[$];
  logic [7:0] mrx[$];
  logic [7:0] mctl;
  bit         movr;

  function automatic int m_cap();
    return mctl[0] ? DEPTH : 1;
  endfunction

  function automatic int rx_thr();
    if (!mctl[0]) return 1;
    case (mctl[7:6])
      2'd0: return 1;
      2'd1: return DEPTH/4;
      2'd2: return DEPTH/2;
      default: return DEPTH-2;
    endcase
  endfunction

  function automatic int tx_thr();
    if (!mctl[0]) return 0;
    case (mctl[5:4])
      2'd0: return 0;
      2'd1: return 2;
      2'd2: return DEPTH/4;
      default: return DEPTH/2;
    endcase
  endfunction

  function automatic logic [4:0] exp_status();
    logic [4:0] s;
    s[0] = (mtx.size() != 0) || (mrx.size() != 0);
    s[1] = mtx.size() < m_cap();
    s[2] = mtx.size() == 0;
    s[3] = mrx.size() != 0;
    s[4] = mrx.size() == m_cap();
    return s;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R9 tx_level", int'(tx_level), mtx.size());
    chk("R9 rx_level", int'(rx_level), mrx.size());
    chk("R8 status", int'(status), int'(exp_status()));
    chk("R3 host_tx_ready", int'(host_tx_ready), int'(mtx.size() < m_cap()));
    chk("R4 rx_overrun", int'(rx_overrun), int'(movr));
    chk("R6 rx_trig", int'(rx_trig), int'(int'(mrx.size()) >= rx_thr()));
    chk("R7 tx_trig", int'(tx_trig), int'(int'(mtx.size()) <= tx_thr()));
    chk("R2 eng_tx_valid", int'(eng_tx_valid), int'(mtx.size() != 0));
    chk("R2 host_rx_valid", int'(host_rx_valid), int'(mrx.size() != 0));
    if (mtx.size() != 0) chk("R2 eng_tx_data", int'(eng_tx_data), int'(mtx[0]));
    if (mrx.size() != 0) chk("R2 host_rx_data", int'(host_rx_data), int'(mrx[0]));
  endtask

  // called just after a falling edge; applies inputs for one rising edge
  task automatic step(input bit tpush, input logic [7:0] td, input bit tpop,
                      input bit rpush, input logic [7:0] rd, input bit rpop,
                      input bit cw, input logic [7:0] cb);
    bit en, tfl, rfl, tpush_ok, tpop_ok, rpush_ok, rpop_ok;
    host_tx_valid = tpush; host_tx_data = td; eng_tx_ready = tpop;
    eng_rx_valid = rpush; eng_rx_data = rd; host_rx_ready = rpop;
    ctl_wr = cw; ctl_byte = cb;
    en  = mctl[0];
    rfl = cw && (cb[1] || (cb[0] != en));
    tfl = cw && (cb[2] || (cb[0] != en));
    tpush_ok = tpush && (mtx.size() < m_cap());
    tpop_ok  = tpop && (mtx.size() != 0);
    rpush_ok = rpush && (mrx.size() < m_cap());
    rpop_ok  = rpop && (mrx.size() != 0);
    if (tfl) mtx.delete();
    else begin
      if (tpop_ok) void'(mtx.pop_front());
      if (tpush_ok) mtx.push_back(td);
    end
    if (rfl) begin
      mrx.delete();
      movr = 1'b0;
    end else begin
      if (rpush && !rpush_ok) movr = 1'b1;
      if (rpop_ok) void'(mrx.pop_front());
      if (rpush_ok) mrx.push_back(rd);
    end
    if (cw) mctl = cb & 8'hF9;
    @(posedge clk);
    @(negedge clk);
    host_tx_valid = 1'b0; eng_tx_ready = 1'b0; eng_rx_valid = 1'b0;
    host_rx_ready = 1'b0; ctl_wr = 1'b0;
    compare_all();
  endtask

  task automatic idle();
    step(0, 8'h00, 0, 0, 8'h00, 0, 0, 8'h00);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    int pp_t, pc_t, pp_r, pc_r;
    void'($urandom(32'h0005_EED5));
    rst_n = 1'b0; ctl_wr = 0; ctl_byte = 0;
    host_tx_valid = 0; host_tx_data = 0; eng_tx_ready = 0;
    eng_rx_valid = 0; eng_rx_data = 0; host_rx_ready = 0;
    mctl = 8'h00; movr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 status", int'(status), 5'b00110);
    chk("R1 levels", int'(tx_level) + int'(rx_level), 0);
    chk("R1 tx_trig", int'(tx_trig), 1);
    chk("R1 rx_trig", int'(rx_trig), 0);
    chk("R1 rx_overrun", int'(rx_overrun), 0);
    compare_all();

    // R10 holding mode: one byte per side
    step(1, 8'hA1, 0, 1, 8'hB1, 0, 0, 8'h00);
    step(1, 8'hA2, 0, 1, 8'hB2, 0, 0, 8'h00);
    chk("R10 tx holds one", int'(tx_level), 1);
    chk("R10 rx holds one", int'(rx_level), 1);
    chk("R4 overrun in holding mode", int'(rx_overrun), 1);
    step(0, 8'h00, 1, 0, 8'h00, 1, 0, 8'h00);
    // R12 pop on empty
    step(0, 8'h00, 1, 0, 8'h00, 1, 0, 8'h00);
    chk("R12 tx empty pop", int'(tx_level), 0);
    chk("R12 rx empty pop", int'(host_rx_valid), 0);

    // R11 enabling flushes held bytes and clears overrun
    step(1, 8'hC3, 0, 1, 8'hD3, 0, 0, 8'h00);
    step(0, 8'h00, 0, 0, 8'h00, 0, 1, 8'hC1);
    chk("R11 tx flushed", int'(tx_level), 0);
    chk("R11 rx flushed", int'(rx_level), 0);

    // fill both queues past capacity (R3, R4, R6 code 3)
    for (int i = 0; i < DEPTH + 2; i++) step(1, 8'(i + 8'h10), 0, 1, 8'(8'h80 + i), 0, 0, 8'h00);
    chk("R3 tx full ready low", int'(host_tx_ready), 0);
    chk("R2 tx depth", int'(tx_level), DEPTH);
    chk("R4 rx overrun", int'(rx_overrun), 1);
    chk("R6 rx_trig code3 full", int'(rx_trig), 1);
    // R5 receive clear keeps transmit side and is not stored
    step(0, 8'h00, 0, 0, 8'h00, 0, 1, 8'h73);
    chk("R5 rx cleared", int'(rx_level), 0);
    chk("R5 overrun cleared", int'(rx_overrun), 0);
    chk("R5 tx kept", int'(tx_level), DEPTH);
    step(0, 8'h00, 0, 1, 8'h55, 0, 0, 8'h00);
    chk("R5 push after clear", int'(rx_level), 1);
    // drain transmit in order, watching R7 code 3 crossing
    for (int i = 0; i < DEPTH + 1; i++) step(0, 8'h00, 1, 0, 8'h00, 0, 0, 8'h00);
    step(0, 8'h00, 0, 0, 8'h00, 0, 1, 8'h05);
    chk("R5 tx clear idle", int'(tx_level), 0);

    // random phase
    pp_t = 50; pc_t = 50; pp_r = 50; pc_r = 50;
    for (int c = 0; c < 6000; c++) begin
      bit cw;
      logic [7:0] cb;
      if (c % 250 == 0) begin
        pp_t = 10 + 40 * ($urandom % 3); pc_t = 10 + 40 * ($urandom % 3);
        pp_r = 10 + 40 * ($urandom % 3); pc_r = 10 + 40 * ($urandom % 3);
      end
      cw = ($urandom % 150) == 0;
      cb = 8'($urandom);
      cb[0] = ($urandom % 10) != 0;
      if (($urandom % 4) != 0) cb[2:1] = 2'b00;
      step(($urandom % 100) < pp_t, 8'($urandom), ($urandom % 100) < pc_t,
           ($urandom % 100) < pp_r, 8'($urandom), ($urandom % 100) < pc_r, cw, cb);
    end

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule